// File: doc/BRIEF.md
# Dual-Identity Two-Wire Slave Controller

This block is a synchronous slave for the two-wire (I2C-style) serial bus. It answers two device identities on the same bus. One identity reaches an 8192-byte memory through a 13-bit address; the other reaches a 15-entry register file through a one-byte address. SCL and SDA are sampled with the system clock. The block drives SDA only through an open-drain enable, where a high enable pulls the line low.

Each identity keeps its own auto-incrementing pointer, and neither pointer is disturbed by traffic to the other identity. A read issued with no new address continues where the previous access stopped. Memory writes are checked against a two-bit protection setting, and the block refuses any byte that falls in the protected range. Storage lives outside the block. It is reached through a simple port: one write strobe and a read-data input, which must show the data at the presented address one clock after the address settles.

Top module: `dual_id_twi_slave`

## Requirements
- R1: The first byte after a start is the device byte. Bits 7:4 equal to 1010b select the memory and 1101b select the registers. Bits 3:1 must be 000b, and bit 0 set to 1 requests a read. A matching device byte is acknowledged. Any other device byte gets no acknowledge, and SDA stays released until the next start.
- R2: A memory write sends its address as two bytes, high byte first. Only the low 13 bits are used, so the top 3 bits of the high byte have no effect.
- R3: A register write sends its address as one byte. An address above 14 (0Eh) is not acknowledged, the transaction is dropped, and the register pointer keeps its value.
- R4: Each accepted data byte advances the pointer of its identity by one. The memory pointer wraps from 1FFFh to 0000h, and the register pointer wraps from 14 to 0.
- R5: Memory transactions leave the register pointer unchanged, and register transactions leave the memory pointer unchanged.
- R6: Once the eighth data bit of a write byte has arrived, the block writes that byte with one strobe before it sends the acknowledge. A start or stop that arrives before the eighth bit causes no write.
- R7: The protection input wp_mode sets which memory addresses are protected. 00 protects none, 01 protects 0000h–07FFh, 10 protects 0000h–0FFFh and 11 protects all addresses. A data byte aimed at a protected address gets no acknowledge and no strobe, and the transaction is dropped.
- R8: Read data leaves MSB first. Each bit changes after an SCL fall. The block sends another byte only if the master acknowledges; a not-acknowledge ends the read with SDA released.
- R9: A repeated start that follows the address bytes of a write turns the transaction into a read. The read starts at the address just loaded.
- R10: A start or stop at any point aborts the current transaction and releases SDA. A start re-arms the block for a device byte.
- R11: After reset SDA is released, both pointers are zero and neither write strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as sampled |
| sda_i | input | 1 | Bus data line as sampled |
| sda_oe | output | 1 | When high, pull SDA low |
| wp_mode | input | 2 | Memory protection setting (R7) |
| mem_addr | output | 13 | Memory pointer / access address |
| mem_we | output | 1 | Memory write strobe, one clock |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data at mem_addr |
| reg_addr | output | 4 | Register pointer / access address |
| reg_we | output | 1 | Register write strobe, one clock |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data at reg_addr |

## Verification
Two things can meet at the end of a data byte: the write commit on the eighth bit and a start or stop condition from the master. The bench provokes this by cutting a write short after seven bits with a stop, and also with a repeated start. It then checks that the count of write strobes has not moved and that a later read returns the old contents. The acknowledge decision can also meet the protection boundary in the same byte, and this is judged byte by byte against a behavioural model of the protected ranges. In every bus bit, the bench compares the sampled SDA drive with what the model predicts.

// File: rtl/twi_pkg.sv
package twi_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_AHI,
        PH_ALO,
        PH_RADR,
        PH_WR,
        PH_RD,
        PH_SKIP
    } phase_e;

    typedef enum logic {
        TG_MEM,
        TG_REG
    } tgt_e;

    localparam logic [3:0] ID_MEM = 4'b1010;
    localparam logic [3:0] ID_REG = 4'b1101;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    logic [STAGES-1:0] scl_q, sda_q;
    logic              scl_p_q, sda_p_q;
    logic              scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q   <= '1;
            sda_q   <= '1;
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_q   <= {scl_q[STAGES-2:0], scl_i};
            sda_q   <= {sda_q[STAGES-2:0], sda_i};
            scl_p_q <= scl_q[STAGES-1];
            sda_p_q <= sda_q[STAGES-1];
        end
    end

    assign scl_s    = scl_q[STAGES-1];
    assign sda_s    = sda_q[STAGES-1];
    assign scl_rise = scl_s & ~scl_p_q;
    assign scl_fall = ~scl_s & scl_p_q;
    // SDA moving while SCL stays high marks a bus condition
    assign start_c  = scl_s & scl_p_q & sda_p_q & ~sda_s;
    assign stop_c   = scl_s & scl_p_q & ~sda_p_q & sda_s;

endmodule

// File: rtl/twi_protect.sv
module twi_protect #(
    parameter int AW = 13
) (
    input  logic [1:0]    wp_mode,
    input  logic [AW-1:0] addr,
    output logic          blocked
);
    always_comb begin
        case (wp_mode)
            2'b01:   blocked = (addr[AW-1:AW-2] == 2'b00);
            2'b10:   blocked = ~addr[AW-1];
            2'b11:   blocked = 1'b1;
            default: blocked = 1'b0;
        endcase
    end
endmodule

// File: rtl/dual_id_twi_slave.sv
module dual_id_twi_slave
    import twi_pkg::*;
#(
    parameter int MEM_AW      = 13,
    parameter int REG_N       = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [1:0]        wp_mode,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic [3:0]        reg_addr,
    output logic              reg_we,
    output logic [7:0]        reg_wdata,
    input  logic [7:0]        reg_rdata
);
    localparam int              REG_AW    = 4;
    localparam logic [REG_AW-1:0] REG_LAST = REG_AW'(REG_N - 1);
    localparam logic [7:0]      REG_LAST8 = 8'(REG_N - 1);

    typedef struct packed {
        phase_e            ph;
        tgt_e              tgt;
        logic              rw;
        logic [3:0]        bcnt;
        logic              ackph;
        logic              mack;
        logic [7:0]        sh;
        logic [7:0]        tx;
        logic              oe;
        logic [MEM_AW-1:0] mptr;
        logic [REG_AW-1:0] rptr;
        logic              mwe;
        logic              rwe;
        logic [7:0]        wd;
    } st_t;

    st_t  q, d;
    logic sda_s, scl_rise, scl_fall, start_c, stop_c;
    logic blocked;
    logic [7:0] rdata_sel;
    logic [REG_AW-1:0] rptr_next;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_c  (start_c),
        .stop_c   (stop_c)
    );

    twi_protect #(.AW(MEM_AW)) u_prot (
        .wp_mode (wp_mode),
        .addr    (q.mptr),
        .blocked (blocked)
    );

    assign rdata_sel = (q.tgt == TG_MEM) ? mem_rdata : reg_rdata;
    assign rptr_next = (q.rptr == REG_LAST) ? '0 : q.rptr + REG_AW'(1);

    always_comb begin
        d     = q;
        d.mwe = 1'b0;
        d.rwe = 1'b0;
        if (stop_c) begin
            d.ph    = PH_IDLE;
            d.oe    = 1'b0;
            d.bcnt  = '0;
            d.ackph = 1'b0;
        end else if (start_c) begin
            d.ph    = PH_DEV;
            d.oe    = 1'b0;
            d.bcnt  = '0;
            d.ackph = 1'b0;
        end else if (q.ph != PH_IDLE && q.ph != PH_SKIP) begin
            if (scl_rise) begin
                if (q.ackph) begin
                    d.mack = ~sda_s;
                end else begin
                    d.sh   = {q.sh[6:0], sda_s};
                    d.bcnt = q.bcnt + 4'd1;
                end
            end else if (scl_fall) begin
                if (q.ackph) begin
                    // acknowledge clock finished
                    d.ackph = 1'b0;
                    d.bcnt  = '0;
                    d.oe    = 1'b0;
                    case (q.ph)
                        PH_DEV: begin
                            if (q.rw) begin
                                d.ph = PH_RD;
                                d.tx = rdata_sel;
                                d.oe = ~rdata_sel[7];
                            end else begin
                                d.ph = (q.tgt == TG_MEM) ? PH_AHI : PH_RADR;
                            end
                        end
                        PH_AHI:          d.ph = PH_ALO;
                        PH_ALO, PH_RADR: d.ph = PH_WR;
                        PH_WR: begin
                            if (q.tgt == TG_MEM) d.mptr = q.mptr + MEM_AW'(1);
                            else                 d.rptr = rptr_next;
                        end
                        PH_RD: begin
                            if (q.mack) begin
                                d.tx = rdata_sel;
                                d.oe = ~rdata_sel[7];
                            end else begin
                                d.ph = PH_SKIP;
                            end
                        end
                        default: ;
                    endcase
                end else if (q.bcnt == 4'd8) begin
                    // eighth bit in: decide acknowledge
                    d.ackph = 1'b1;
                    d.oe    = 1'b1;
                    case (q.ph)
                        PH_DEV: begin
                            if ((q.sh[7:4] == ID_MEM || q.sh[7:4] == ID_REG) && q.sh[3:1] == 3'b000) begin
                                d.tgt = (q.sh[7:4] == ID_MEM) ? TG_MEM : TG_REG;
                                d.rw  = q.sh[0];
                            end else begin
                                d.ph    = PH_SKIP;
                                d.oe    = 1'b0;
                                d.ackph = 1'b0;
                            end
                        end
                        PH_AHI: d.mptr[MEM_AW-1:8] = q.sh[MEM_AW-9:0];
                        PH_ALO: d.mptr[7:0]        = q.sh;
                        PH_RADR: begin
                            if (q.sh <= REG_LAST8) begin
                                d.rptr = q.sh[REG_AW-1:0];
                            end else begin
                                d.ph    = PH_SKIP;
                                d.oe    = 1'b0;
                                d.ackph = 1'b0;
                            end
                        end
                        PH_WR: begin
                            if (q.tgt == TG_MEM && blocked) begin
                                d.ph    = PH_SKIP;
                                d.oe    = 1'b0;
                                d.ackph = 1'b0;
                            end else begin
                                d.mwe = (q.tgt == TG_MEM);
                                d.rwe = (q.tgt == TG_REG);
                                d.wd  = q.sh;
                            end
                        end
                        PH_RD: begin
                            d.oe = 1'b0;
                            if (q.tgt == TG_MEM) d.mptr = q.mptr + MEM_AW'(1);
                            else                 d.rptr = rptr_next;
                        end
                        default: ;
                    endcase
                end else if (q.ph == PH_RD) begin
                    d.oe = ~q.tx[3'(4'd7 - q.bcnt)];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_oe    = q.oe;
    assign mem_addr  = q.mptr;
    assign mem_we    = q.mwe;
    assign mem_wdata = q.wd;
    assign reg_addr  = q.rptr;
    assign reg_we    = q.rwe;
    assign reg_wdata = q.wd;

    AST_NO_PROTECTED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !blocked); // R7

    AST_REG_PTR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr <= REG_LAST); // R3

    AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        start_c |=> (q.ph == PH_DEV && !sda_oe)); // R10

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> !sda_oe); // R10

    AST_MEM_PTR_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.tgt == TG_REG && q.ph inside {PH_RADR, PH_WR, PH_RD}) |=> $stable(mem_addr)); // R5

    AST_MEM_STROBE_SOLO: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we); // R6

endmodule

// File: tb/tb_dual_id_twi_slave.sv
module tb_dual_id_twi_slave;

    localparam int HP = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic [1:0] wp = 2'b00;
    logic sda_oe, mem_we, reg_we;
    logic [12:0] mem_addr;
    logic [7:0] mem_wdata, reg_wdata;
    logic [7:0] mem_rdata = 8'h00;
    logic [7:0] reg_rdata = 8'h00;
    logic [3:0] reg_addr;
    wire sda_line = m_sda & ~sda_oe;

    dual_id_twi_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .wp_mode(wp), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // storage behind the ports
    logic [7:0] mem_arr [int];
    logic [7:0] reg_arr [16];
    int act_mwe = 0, act_rwe = 0;

    // reference model
    logic [7:0] ref_mem [int];
    logic [7:0] ref_reg [16];
    int ref_mptr = 0, ref_rptr = 0;
    int exp_mwe = 0, exp_rwe = 0;

    int nchk = 0, nerr = 0;
    bit done = 0;

    function automatic logic [7:0] peek_mem(int k);
        return mem_arr.exists(k) ? mem_arr[k] : 8'h00;
    endfunction
    function automatic logic [7:0] peek_ref(int k);
        return ref_mem.exists(k) ? ref_mem[k] : 8'h00;
    endfunction
    function automatic bit ref_blocked(int a, logic [1:0] w);
        int lim;
        lim = (w == 2'd0) ? 0 : (w == 2'd1) ? 2048 : (w == 2'd2) ? 4096 : 8192;
        return a < lim;
    endfunction

    always @(posedge clk) begin
        if (mem_we) begin mem_arr[int'(mem_addr)] = mem_wdata; act_mwe++; end
        if (reg_we) begin reg_arr[reg_addr] = reg_wdata; act_rwe++; end
    end
    always @(negedge clk) begin
        mem_rdata <= peek_mem(int'(mem_addr));
        reg_rdata <= reg_arr[reg_addr];
    end

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        m_sda = 1'b1; tick(HP);
        m_scl = 1'b1; tick(HP);
        m_sda = 1'b0; tick(HP);
        m_scl = 1'b0; tick(2);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; tick(HP);
        m_scl = 1'b1; tick(HP);
        m_sda = 1'b1; tick(HP);
    endtask

    task automatic bus_bit(input logic b, output logic r, output logic oe);
        m_sda = b; tick(HP);
        m_scl = 1'b1; tick(HP/2);
        r = sda_line; oe = sda_oe;
        tick(HP/2);
        m_scl = 1'b0; tick(2);
    endtask

    task automatic wr_byte(logic [7:0] v, bit exp_ack, string req);
        logic r, oe;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(v[i], r, oe);
            chk({req, " slave quiet during master bits"}, oe, 0);
        end
        bus_bit(1'b1, r, oe);
        chk({req, " acknowledge"}, !r, exp_ack);
    endtask

    task automatic rd_byte(logic [7:0] exp, bit mack, string req);
        logic r, oe;
        logic [7:0] v;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, r, oe);
            v[i] = r;
        end
        chk({req, " read data"}, v, exp);
        bus_bit(!mack, r, oe);
        chk("R8 slave released in master ack slot", oe, 0);
    endtask

    task automatic send_bits(logic [7:0] v, int n);
        logic r, oe;
        for (int i = 7; i > 7 - n; i--) bus_bit(v[i], r, oe);
    endtask

    task automatic mem_setaddr(logic [7:0] hi, logic [7:0] lo);
        bus_start;
        wr_byte(8'hA0, 1, "R1 memory id");
        wr_byte(hi, 1, "R2 address high");
        wr_byte(lo, 1, "R2 address low");
        ref_mptr = {hi[4:0], lo};
    endtask

    task automatic mem_write(logic [7:0] hi, logic [7:0] lo, logic [7:0] d0, int n, string req);
        logic [7:0] v;
        bit ok;
        mem_setaddr(hi, lo);
        for (int i = 0; i < n; i++) begin
            v  = d0 + 8'(i * 29);
            ok = !ref_blocked(ref_mptr, wp);
            wr_byte(v, ok, req);
            if (!ok) break;
            ref_mem[ref_mptr] = v;
            exp_mwe++;
            ref_mptr = (ref_mptr + 1) % 8192;
        end
        bus_stop;
    endtask

    task automatic reg_setaddr(logic [7:0] a);
        bus_start;
        wr_byte(8'hD0, 1, "R1 register id");
        wr_byte(a, 1, "R3 legal register address");
        ref_rptr = int'(a);
    endtask

    task automatic reg_write(logic [7:0] a, logic [7:0] d0, int n);
        logic [7:0] v;
        bus_start;
        wr_byte(8'hD0, 1, "R1 register id");
        if (a > 8'd14) begin
            wr_byte(a, 0, "R3 illegal register address");
            wr_byte(d0, 0, "R3 dropped after refusal");
        end else begin
            wr_byte(a, 1, "R3 legal register address");
            ref_rptr = int'(a);
            for (int i = 0; i < n; i++) begin
                v = d0 + 8'(i * 17);
                wr_byte(v, 1, "R4 register data");
                ref_reg[ref_rptr] = v;
                exp_rwe++;
                ref_rptr = (ref_rptr == 14) ? 0 : ref_rptr + 1;
            end
        end
        bus_stop;
    endtask

    task automatic read_cur(bit is_reg, int n, string req);
        logic [7:0] e;
        bus_start;
        wr_byte(is_reg ? 8'hD1 : 8'hA1, 1, "R1 read id");
        for (int i = 0; i < n; i++) begin
            if (is_reg) begin
                e = ref_reg[ref_rptr];
                ref_rptr = (ref_rptr == 14) ? 0 : ref_rptr + 1;
            end else begin
                e = peek_ref(ref_mptr);
                ref_mptr = (ref_mptr + 1) % 8192;
            end
            rd_byte(e, i < n - 1, req);
        end
        bus_stop;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin reg_arr[i] = 8'h00; ref_reg[i] = 8'h00; end
        tick(3);
        chk("R11 SDA released in reset", sda_oe, 0);
        chk("R11 memory strobe idle", mem_we, 0);
        chk("R11 register strobe idle", reg_we, 0);
        rst_n = 1'b1;
        tick(5);
        chk("R11 memory pointer zero", mem_addr, 0);
        chk("R11 register pointer zero", reg_addr, 0);

        // plain write then repeated-start read of the same range
        mem_write(8'h00, 8'h10, 8'h3C, 4, "R6 memory write");
        mem_setaddr(8'h00, 8'h10);
        read_cur(0, 4, "R9 read after repeated start");
        // continue from the current pointer
        mem_write(8'h00, 8'h14, 8'h81, 2, "R6 memory write");
        mem_setaddr(8'h00, 8'h12);
        read_cur(0, 2, "R8 sequential read");
        read_cur(0, 2, "R4 current address continues");

        // register traffic must not move the memory pointer
        reg_write(8'd3, 8'h55, 3);
        read_cur(0, 1, "R5 memory pointer kept");
        reg_setaddr(8'd3);
        read_cur(1, 3, "R9 register read");
        mem_setaddr(8'h00, 8'h10);
        bus_stop;
        read_cur(1, 1, "R5 register pointer kept");

        // illegal register addresses
        reg_write(8'd15, 8'hEE, 1);
        reg_write(8'h40, 8'hEE, 1);
        read_cur(1, 1, "R3 pointer unchanged after refusal");

        // wrap-around, upper address bits ignored
        mem_write(8'hFF, 8'hFF, 8'hA5, 2, "R4 memory wrap");
        mem_setaddr(8'hE0, 8'h00);
        read_cur(0, 1, "R2 top bits ignored");
        mem_setaddr(8'h1F, 8'hFF);
        read_cur(0, 2, "R4 read wraps");
        reg_write(8'd14, 8'h70, 2);
        reg_setaddr(8'd14);
        read_cur(1, 2, "R4 register wrap");

        // protection ranges
        wp = 2'b01;
        mem_write(8'h07, 8'hFF, 8'h11, 2, "R7 quarter protected");
        mem_write(8'h08, 8'h00, 8'h22, 2, "R7 above quarter open");
        wp = 2'b10;
        mem_write(8'h0F, 8'hFF, 8'h33, 1, "R7 half protected");
        mem_write(8'h10, 8'h00, 8'h44, 1, "R7 above half open");
        wp = 2'b11;
        mem_write(8'h1A, 8'hBC, 8'h55, 1, "R7 full protected");
        wp = 2'b00;
        mem_setaddr(8'h07, 8'hFF);
        read_cur(0, 3, "R7 protected bytes unchanged");
        chk("R7 strobe count", act_mwe, exp_mwe);

        // foreign device bytes
        bus_start;
        wr_byte(8'h90, 0, "R1 unknown id");
        wr_byte(8'hFF, 0, "R1 quiet until start");
        bus_stop;
        bus_start;
        wr_byte(8'hA4, 0, "R1 nonzero bits 3:1");
        bus_stop;

        // abort before the eighth bit
        mem_setaddr(8'h00, 8'h10);
        send_bits(8'h00, 7);
        bus_stop;
        chk("R6 no write on stop abort", act_mwe, exp_mwe);
        mem_setaddr(8'h00, 8'h11);
        send_bits(8'hFF, 3);
        read_cur(0, 2, "R10 start mid byte aborts");
        chk("R6 no write on start abort", act_mwe, exp_mwe);
        chk("R10 SDA released after stop", sda_oe, 0);

        chk("R6 memory strobes", act_mwe, exp_mwe);
        chk("R4 register strobes", act_rwe, exp_rwe);
        foreach (ref_mem[k]) chk("R6 stored memory byte", peek_mem(k), ref_mem[k]);
        for (int i = 0; i < 15; i++) chk("R4 stored register byte", reg_arr[i], ref_reg[i]);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog R10 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule